// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Register Interface

This block is a watchdog timer placed on a simple APB-style register bus and run from one clock. Software selects one of sixteen power-of-two periods. It arms the watchdog through a control register and must keep writing a fixed key word to a restart register before the count runs out. If the count runs out, the block responds in one of two ways chosen by a mode bit. In direct mode it raises a system reset request at once. In two-stage mode it first raises an interrupt and starts a second period, and it requests reset only if that second period also runs out with the interrupt still pending.

The reset request is a level that stays high until the block itself is reset. The pulse generator that acts on it lies outside this block. A `BASE_SHIFT` parameter sets the shortest period. The default of 16 gives periods of 2^(16+i) cycles, and a smaller value shortens every period by the same factor.

Top module: `wdog_apb`

## Requirements
- R1: Transfers are zero-wait: a write takes effect on the clock edge where `psel`, `penable` and `pwrite` are all high, and read data is valid during the access phase. The register map is as follows. 0x00 holds the enable bit in bit 0 and the mode bit in bit 1, where 1 selects two-stage mode. 0x04 holds the running period select in bits [3:0] and the initial period select in bits [7:4]. 0x08 reads the counter. 0x10 reads 1 in bit 0 while an interrupt is pending. 0xF4 reads 0x40, with bit 6 marking the fixed power-of-two table. Any other address reads 0.
- R2: After reset, every register reads 0, the parameter register reads 0x40, and `irq` and `rst_req` are low.
- R3: Once set, the enable bit cannot be cleared by any write. Only the block reset clears it.
- R4: While the block is disabled, the counter holds its value and neither `irq` nor `rst_req` rises.
- R5: The write that sets enable loads the counter with 2^(BASE_SHIFT+init_select)-1. After that, the counter drops by one on every clock.
- R6: An expiry happens on the 2^(BASE_SHIFT+sel)-th clock edge after the counter is loaded. The counter then reloads from the running period select.
- R7: In direct mode, an expiry raises `rst_req`, and `rst_req` stays high until the block is reset.
- R8: In two-stage mode, a first expiry sets the pending interrupt (`irq`) and reloads the counter. An expiry while the interrupt is still pending raises `rst_req`, so reset comes two periods after the last restart.
- R9: Writing exactly 0x00000076 to 0x0C while enabled reloads the counter from the running select and clears the pending interrupt. Any other value written there has no effect.
- R10: A read of 0x14 returns 0 and clears the pending interrupt without reloading the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data |
| irq | output | 1 | Pending interrupt, two-stage mode |
| rst_req | output | 1 | Sticky system reset request |

## Verification
The assertions assume that transfers follow the two-phase protocol. Under that protocol `penable` rises only in the cycle after `psel`, and the address and data stay fixed through the access phase. They also assume that only aligned, mapped addresses carry meaning. The bench issues every access through one write task and one read task, which always produce a setup phase followed by a single access phase. The random part draws period selects and restart delays only from ranges where the next restart lands before expiry. The directed parts place their checks on the exact edges of expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int SEL_W = 4;
  localparam logic [7:0] A_CTRL  = 8'h00;
  localparam logic [7:0] A_RANGE = 8'h04;
  localparam logic [7:0] A_COUNT = 8'h08;
  localparam logic [7:0] A_KICK  = 8'h0C;
  localparam logic [7:0] A_STAT  = 8'h10;
  localparam logic [7:0] A_ACK   = 8'h14;
  localparam logic [7:0] A_PARAM = 8'hF4;
  localparam logic [31:0] KICK_KEY = 32'h0000_0076;
  localparam int FIXED_TABLE_BIT = 6;

  typedef struct packed {
    logic             enable;
    logic             irq_mode;
    logic [SEL_W-1:0] init_sel;
    logic [SEL_W-1:0] run_sel;
  } wdog_cfg_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              pending,
  output logic [DATA_W-1:0] prdata,
  output wdog_cfg_t         cfg,
  output logic              start,
  output logic              kick,
  output logic              ack_rd
);
  wdog_cfg_t cfg_q, cfg_d;
  logic acc_wr, acc_rd, hit_ctrl, hit_range, cfg_en;

  assign acc_wr    = psel & penable & pwrite;
  assign acc_rd    = psel & penable & ~pwrite;
  assign hit_ctrl  = (paddr == ADDR_W'(A_CTRL));
  assign hit_range = (paddr == ADDR_W'(A_RANGE));
  assign cfg_en    = acc_wr & (hit_ctrl | hit_range);

  always_comb begin
    cfg_d = cfg_q;
    if (hit_ctrl) begin
      cfg_d.enable   = cfg_q.enable | pwdata[0];
      cfg_d.irq_mode = pwdata[1];
    end
    if (hit_range) begin
      cfg_d.run_sel  = pwdata[SEL_W-1:0];
      cfg_d.init_sel = pwdata[2*SEL_W-1:SEL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  assign cfg    = cfg_q;
  assign start  = acc_wr & hit_ctrl & pwdata[0] & ~cfg_q.enable;
  assign kick   = acc_wr & (paddr == ADDR_W'(A_KICK)) &
                  (pwdata == DATA_W'(KICK_KEY)) & cfg_q.enable;
  assign ack_rd = acc_rd & (paddr == ADDR_W'(A_ACK));

  always_comb begin
    prdata = '0;
    if (paddr == ADDR_W'(A_CTRL)) begin
      prdata[0] = cfg_q.enable;
      prdata[1] = cfg_q.irq_mode;
    end else if (paddr == ADDR_W'(A_RANGE)) begin
      prdata[2*SEL_W-1:0] = {cfg_q.init_sel, cfg_q.run_sel};
    end else if (paddr == ADDR_W'(A_COUNT)) begin
      prdata[CNT_W-1:0] = count;
    end else if (paddr == ADDR_W'(A_STAT)) begin
      prdata[0] = pending;
    end else if (paddr == ADDR_W'(A_PARAM)) begin
      prdata[FIXED_TABLE_BIT] = 1'b1;
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int BASE_SHIFT = 16,
  parameter int SEL_W      = 4,
  parameter int CNT_W      = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start,
  input  logic             kick,
  input  logic [SEL_W-1:0] init_sel,
  input  logic [SEL_W-1:0] run_sel,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  function automatic logic [CNT_W-1:0] span(input logic [SEL_W-1:0] s);
    return (CNT_W'(1) << (BASE_SHIFT + int'(s))) - CNT_W'(1);
  endfunction

  assign expire = enable & (cnt_q == '0) & ~kick & ~start;
  assign cnt_en = start | kick | enable;

  always_comb begin
    if (start)               cnt_d = span(init_sel);
    else if (kick || expire) cnt_d = span(run_sel);
    else                     cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/wdog_resp.sv
module wdog_resp (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_mode,
  input  logic expire,
  input  logic kick,
  input  logic ack_rd,
  output logic irq,
  output logic rst_req
);
  logic pend_q, pend_d, rreq_q, rreq_d, st_en;

  always_comb begin
    pend_d = pend_q;
    if (expire && irq_mode && !pend_q) pend_d = 1'b1;
    else if (kick || ack_rd)           pend_d = 1'b0;
    rreq_d = rreq_q | (expire & (~irq_mode | pend_q));
  end

  assign st_en = expire | kick | ack_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      rreq_q <= 1'b0;
    end else if (st_en) begin
      pend_q <= pend_d;
      rreq_q <= rreq_d;
    end
  end

  assign irq     = pend_q;
  assign rst_req = rreq_q;
endmodule

// File: rtl/wdog_apb.sv
module wdog_apb
  import wdog_pkg::*;
#(
  parameter int BASE_SHIFT = 16,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              irq,
  output logic              rst_req
);
  localparam int CNT_W = BASE_SHIFT + (1 << SEL_W) - 1;

  logic [1:0]       rst_sync;
  logic             rst_sync_n;
  wdog_cfg_t        cfg;
  logic             start, kick, ack_rd, expire;
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .count(count),
    .pending(irq), .prdata(prdata), .cfg(cfg), .start(start),
    .kick(kick), .ack_rd(ack_rd)
  );

  wdog_counter #(.BASE_SHIFT(BASE_SHIFT), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .enable(cfg.enable), .start(start),
    .kick(kick), .init_sel(cfg.init_sel), .run_sel(cfg.run_sel),
    .count(count), .expire(expire)
  );

  wdog_resp u_resp (
    .clk(clk), .rst_n(rst_sync_n), .irq_mode(cfg.irq_mode), .expire(expire),
    .kick(kick), .ack_rd(ack_rd), .irq(irq), .rst_req(rst_req)
  );
endmodule

// File: rtl/wdog_apb_chk.sv
module wdog_apb_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic [DATA_W-1:0] prdata,
  input logic              irq,
  input logic              rst_req,
  input logic              en,
  input logic              irq_mode,
  input logic [CNT_W-1:0]  count
);
  logic kick_s, ack_s;
  assign kick_s = psel & penable & pwrite & (paddr == ADDR_W'(8'h0C)) &
                  (pwdata == DATA_W'(32'h76));
  assign ack_s  = psel & penable & ~pwrite & (paddr == ADDR_W'(8'h14));

  p_en_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en);
  p_quiet_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!irq && !rst_req));
  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && count != '0 && !kick_s) |=> count == $past(count) - CNT_W'(1));
  p_rst_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);
  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !kick_s && !ack_s) |=> irq);
  p_two_stage_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_req) && $past(irq_mode)) |-> $past(irq));
  p_kick_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_s && en) |=> !irq);
  p_ack_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_s |-> prdata == '0);
  p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_s && count != '0) |=> !irq);
endmodule

bind wdog_apb wdog_apb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .psel(psel), .penable(penable),
  .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
  .irq(irq), .rst_req(rst_req), .en(cfg.enable), .irq_mode(cfg.irq_mode),
  .count(count)
);

// File: tb/test_wdog_apb.sv
module test_wdog_apb;
  localparam int BS = 2;
  localparam logic [7:0] CTRL = 8'h00, RANGE = 8'h04, COUNT = 8'h08,
                         KICK = 8'h0C, STAT = 8'h10, ACK = 8'h14, PARAM = 8'hF4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, psel, penable, pwrite, irq, rst_req;
  logic [7:0]  paddr;
  logic [31:0] pwdata, prdata;
  int cyc = 0;
  int n_chk = 0, n_err = 0;

  always @(posedge clk) cyc <= cyc + 1;

  wdog_apb #(.BASE_SHIFT(BS)) i_wdog_apb (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq), .rst_req(rst_req)
  );

  function automatic int span(int s);
    return 1 << (BS + s);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_to(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic apb_wr(logic [7:0] a, logic [31:0] d, output int w);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(posedge clk);
    #1;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    w = cyc;
  endtask

  task automatic apb_rd(logic [7:0] a, output logic [31:0] d, output int s);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1;
    d = prdata;
    s = cyc;
    @(posedge clk);
    #1;
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic do_reset();
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; paddr = '0; pwdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int w, s, c0, ck;
    void'($urandom(32'h5eed_0042));

    // R2 / R1: reset state and register map
    do_reset();
    chk("R2 irq", {31'b0, irq}, 0);
    chk("R2 rst_req", {31'b0, rst_req}, 0);
    apb_rd(CTRL, v, s);  chk("R2 ctrl", v, 0);
    apb_rd(RANGE, v, s); chk("R2 range", v, 0);
    apb_rd(COUNT, v, s); chk("R2 count", v, 0);
    apb_rd(STAT, v, s);  chk("R2 status", v, 0);
    apb_rd(PARAM, v, s); chk("R1 param", v, 32'h40);
    apb_rd(8'h20, v, s); chk("R1 unmapped", v, 0);

    // R4: disabled block stays quiet, counter holds
    apb_wr(RANGE, 32'h00, w);
    wait_to(cyc + 60);
    chk("R4 irq", {31'b0, irq}, 0);
    chk("R4 rst_req", {31'b0, rst_req}, 0);
    apb_rd(COUNT, v, s); chk("R4 count held", v, 0);

    // R3: enable cannot be cleared by software
    apb_wr(RANGE, 32'h55, w);
    apb_wr(CTRL, 32'h1, w);
    apb_wr(CTRL, 32'h0, w);
    apb_rd(CTRL, v, s); chk("R3 enable sticky", v, 32'h1);
    apb_rd(RANGE, v, s); chk("R1 range readback", v, 32'h55);

    // R5 / R6 / R7: init field on enable, direct mode reset
    do_reset();
    apb_wr(RANGE, 32'h13, w);          // run sel 3, init sel 1
    apb_wr(CTRL, 32'h1, c0);
    apb_rd(COUNT, v, s);
    chk("R5 init load count", v, span(1) - 1 - (s - c0));
    wait_to(c0 + span(1) - 1);
    chk("R6 no reset before expiry", {31'b0, rst_req}, 0);
    wait_to(c0 + span(1));
    chk("R7 reset on expiry", {31'b0, rst_req}, 1);
    chk("R7 no irq in direct mode", {31'b0, irq}, 0);
    wait_to(c0 + span(1) + 50);
    chk("R7 reset held", {31'b0, rst_req}, 1);

    // R8: two-stage response
    do_reset();
    apb_wr(RANGE, 32'h22, w);
    apb_wr(CTRL, 32'h3, c0);
    wait_to(c0 + span(2) - 1);
    chk("R8 no irq before expiry", {31'b0, irq}, 0);
    wait_to(c0 + span(2));
    chk("R8 irq on first expiry", {31'b0, irq}, 1);
    chk("R8 no reset on first expiry", {31'b0, rst_req}, 0);
    apb_rd(STAT, v, s); chk("R8 status pending", v, 1);
    wait_to(c0 + 2 * span(2) - 1);
    chk("R8 no reset before second expiry", {31'b0, rst_req}, 0);
    wait_to(c0 + 2 * span(2));
    chk("R8 reset on second expiry", {31'b0, rst_req}, 1);

    // R9: kick clears pending and reloads; other values ignored
    do_reset();
    apb_wr(RANGE, 32'h11, w);
    apb_wr(CTRL, 32'h3, c0);
    wait_to(c0 + span(1));
    chk("R9 irq raised", {31'b0, irq}, 1);
    apb_wr(KICK, 32'h76, ck);
    chk("R9 kick clears irq", {31'b0, irq}, 0);
    apb_rd(COUNT, v, s); chk("R9 kick reload", v, span(1) - 1 - (s - ck));
    wait_to(ck + span(1));
    chk("R9 irq again after kick", {31'b0, irq}, 1);
    chk("R9 no reset after kick", {31'b0, rst_req}, 0);
    apb_wr(KICK, 32'h75, w);
    chk("R9 wrong key ignored", {31'b0, irq}, 1);
    wait_to(ck + 2 * span(1) - 1);
    chk("R9 no reset yet", {31'b0, rst_req}, 0);
    wait_to(ck + 2 * span(1));
    chk("R9 wrong key gives reset", {31'b0, rst_req}, 1);

    // R10: acknowledge read clears pending, no reload
    do_reset();
    apb_wr(RANGE, 32'h11, w);
    apb_wr(CTRL, 32'h3, c0);
    wait_to(c0 + span(1));
    apb_rd(ACK, v, s);
    chk("R10 ack reads zero", v, 0);
    chk("R10 ack clears irq", {31'b0, irq}, 0);
    wait_to(c0 + 2 * span(1));
    chk("R10 second expiry re-raises irq", {31'b0, irq}, 1);
    chk("R10 no reset after ack", {31'b0, rst_req}, 0);
    wait_to(c0 + 3 * span(1));
    chk("R10 third expiry resets", {31'b0, rst_req}, 1);

    // R5 / R9: random periods and kick delays in direct mode
    do_reset();
    apb_wr(RANGE, 32'h44, w);
    apb_wr(CTRL, 32'h1, c0);
    for (int it = 0; it < 24; it++) begin
      int idx, d;
      idx = 2 + int'($urandom % 3);
      d = int'($urandom % 4);
      apb_wr(RANGE, 32'(idx | (idx << 4)), w);
      apb_wr(KICK, 32'h76, ck);
      wait_to(ck + d);
      apb_rd(COUNT, v, s);
      chk("R5 random count", v, span(idx) - 1 - (s - ck));
      chk("R9 random no reset", {31'b0, rst_req}, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule